// File: doc/BRIEF.md
# Striped Parity Array Engine

This block places logical strips on an array of `N` member disks protected by one XOR parity strip per stripe, and runs the disk command sequences for reading and writing those strips. Consecutive logical strips go round-robin over the data positions of a stripe. The parity position is either held on the highest disk or rotated from stripe to stripe. A full-stripe write streams the new data to the disks and finishes with the computed parity. A single-strip write runs a read-modify-write of the data and parity strips. When one member has failed and degraded operation is enabled, the block reconstructs that member's strips from the survivors. It also keeps parity correct for writes that land on a stripe containing the dead member.

A strip is one word of `DW` bits. Requests enter on a valid/ready port. Full-stripe data arrives on a separate valid/ready stream of `N-1` beats. The disks are reached through one command port with a one-word read return path. Each request ends with a one-cycle response carrying an error flag and, for reads, the strip value. A failure report input records the first failed member. A second, different failure marks the array unrecoverable.

Top module: `parity_array_engine`

## Requirements
- R1: Logical strip `s` lies in stripe `r = s / (N-1)` at data position `i = s % (N-1)`. The parity disk is `N-1` when `cfg_rotate` is 0 and `(N-1) - (r % N)` when it is 1. Data position `i` lives on disk `i` if `i` is below the parity disk, otherwise on disk `i+1`.
- R2: A full-stripe write (`req_op` = 2, `req_strip` holding the stripe number) accepts exactly `N-1` beats. It writes beat `i` to the disk of data position `i`, then writes the XOR of all beats to the parity disk.
- R3: A single-strip write (`req_op` = 1) on a healthy stripe issues two reads (old data, old parity) and then two writes. The data disk gets the new word, and the parity disk gets old parity XOR old data XOR new data.
- R4: A read (`req_op` = 0) of a strip on a working disk issues one disk read and returns that word with `rsp_err` = 0.
- R5: With `cfg_degraded` = 1, a read of a strip on the failed disk reads the other `N-1` disks of the stripe and returns their XOR. The failed disk is never accessed.
- R6: With `cfg_degraded` = 1, a single-strip write whose parity disk has failed only writes the data disk. If instead its data disk has failed, it reads the other surviving data disks and writes only the parity, with value new data XOR those strips.
- R7: With `cfg_degraded` = 1 and a failed member, a full-stripe write skips the failed disk's write but still folds that beat into parity. A later degraded read returns every strip of the stripe.
- R8: With `cfg_degraded` = 0, a request whose disks include the failed member responds with `rsp_err` = 1 and issues no disk command. For a read this is the data disk, for a single write the data or parity disk, and for a full write any disk.
- R9: A failure report records the member as failed. A report of a different member while one is already failed sets `unrecoverable`, which stays set until reset. While it is set, every request ends in an error.
- R10: `req_op` = 3 is reserved and answers with `rsp_err` = 1 without any disk command.
- R11: A failure report sampled in the same cycle a request is accepted does not change that request. Requests accepted afterwards see the failure.
- R12: After reset `req_ready` is 1 and `failed`, `unrecoverable`, `rsp_valid` and `dsk_valid` are 0. `rsp_valid` is a one-cycle pulse, and `req_ready` is 1 only between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rotate | input | 1 | 1: rotating parity disk, 0: parity on disk N-1 |
| cfg_degraded | input | 1 | Allow operation around a failed member |
| fail_valid | input | 1 | Failure report strobe |
| fail_disk | input | IW | Member reported as failed |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 0 read, 1 single write, 2 full-stripe write, 3 reserved |
| req_strip | input | SW | Logical strip, or stripe number for op 2 |
| req_data | input | DW | New data for op 1 |
| dat_valid | input | 1 | Full-stripe beat valid |
| dat_ready | output | 1 | Full-stripe beat accepted |
| dat_in | input | DW | Full-stripe beat data |
| dsk_valid | output | 1 | Disk command valid |
| dsk_ready | input | 1 | Disk command accepted |
| dsk_we | output | 1 | 1 write, 0 read |
| dsk_id | output | IW | Target member |
| dsk_row | output | SW | Stripe number on the member |
| dsk_wdata | output | DW | Write data |
| dsk_rvalid | input | 1 | Read data return strobe |
| dsk_rdata | input | DW | Read data |
| rsp_valid | output | 1 | Operation complete pulse |
| rsp_err | output | 1 | Operation refused |
| rsp_data | output | DW | Read result (ops 0) |
| failed | output | 1 | A member is recorded as failed |
| failed_id | output | IW | Recorded failed member |
| unrecoverable | output | 1 | Second distinct failure seen |

## Verification
The two functions that can coincide are the acceptance of a request and the recording of a failure report. The bench drives `fail_valid` for disk 2 in the very cycle a read of a strip on disk 2 is accepted. That read must still finish with the true word, one disk command and no error. The next read of the same strip with degraded operation off must be refused without any disk traffic. Status outputs are compared against the bench model on every clock, so the report is also judged to land exactly at that edge.

// File: rtl/parity_array_engine.sv
module parity_array_engine #(
  parameter int N  = 5,
  parameter int DW = 16,
  parameter int SW = 12,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_rotate,
  input  logic          cfg_degraded,
  input  logic          fail_valid,
  input  logic [IW-1:0] fail_disk,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [SW-1:0] req_strip,
  input  logic [DW-1:0] req_data,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [DW-1:0] dat_in,
  output logic          dsk_valid,
  input  logic          dsk_ready,
  output logic          dsk_we,
  output logic [IW-1:0] dsk_id,
  output logic [SW-1:0] dsk_row,
  output logic [DW-1:0] dsk_wdata,
  input  logic          dsk_rvalid,
  input  logic [DW-1:0] dsk_rdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data,
  output logic          failed,
  output logic [IW-1:0] failed_id,
  output logic          unrecoverable
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_FULL, S_WR, S_DONE} st_t;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  st_t st;
  logic [N-1:0]  rmask;
  logic          wait_r, wdat, wpar, fdeg;
  logic [DW-1:0] acc, newd;
  logic [IW-1:0] pd, dd, cnt, rd_id;
  logic [SW-1:0] row;

  function automatic logic [IW-1:0] par_of(input logic [SW-1:0] r, input logic rot);
    logic [SW-1:0] m;
    m = r % SW'(N);
    return rot ? IW'(SW'(N-1) - m) : IW'(N-1);
  endfunction

  function automatic logic [IW-1:0] data_of(input logic [IW-1:0] i, input logic [IW-1:0] p);
    return (i < p) ? i : i + IW'(1);
  endfunction

  wire [SW-1:0] a_row = (req_op == 2'd2) ? req_strip : req_strip / SW'(N-1);
  wire [IW-1:0] a_idx = IW'(req_strip % SW'(N-1));
  wire [IW-1:0] a_par = par_of(a_row, cfg_rotate);
  wire [IW-1:0] a_dat = data_of(a_idx, a_par);
  wire          d_hit = failed && failed_id == a_dat;
  wire          p_hit = failed && failed_id == a_par;
  wire [N-1:0]  dbit  = N'(1) << a_dat;
  wire [N-1:0]  pbit  = N'(1) << a_par;

  logic hit;
  always_comb
    case (req_op)
      2'd0:    hit = d_hit;
      2'd1:    hit = d_hit || p_hit;
      default: hit = failed;
    endcase
  wire bad = (req_op == 2'd3) || unrecoverable || (hit && !cfg_degraded);

  always_comb begin
    rd_id = '0;
    for (int k = N-1; k >= 0; k--)
      if (rmask[k]) rd_id = IW'(k);
  end

  wire [IW-1:0] f_dat  = data_of(cnt, pd);
  wire          f_skip = fdeg && failed_id == f_dat;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign rsp_data  = acc;
  assign dsk_row   = row;
  assign dsk_we    = (st != S_RD);
  assign dat_ready = (st == S_FULL) && (f_skip || dsk_ready);
  assign dsk_valid = (st == S_RD   && rmask != '0 && !wait_r) ||
                     (st == S_FULL && dat_valid && !f_skip) ||
                     (st == S_WR   && (wdat || wpar));
  assign dsk_id    = (st == S_RD) ? rd_id : (st == S_FULL) ? f_dat : (wdat ? dd : pd);
  assign dsk_wdata = (st == S_FULL) ? dat_in : (wdat ? newd : acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; failed <= 1'b0; failed_id <= '0; unrecoverable <= 1'b0;
      rmask <= '0; wait_r <= 1'b0; wdat <= 1'b0; wpar <= 1'b0; fdeg <= 1'b0;
      acc <= '0; newd <= '0; pd <= '0; dd <= '0; cnt <= '0; row <= '0; rsp_err <= 1'b0;
    end else begin
      if (fail_valid) begin
        if (!failed) begin
          failed <= 1'b1; failed_id <= fail_disk;
        end else if (fail_disk != failed_id) unrecoverable <= 1'b1;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          row <= a_row; pd <= a_par; dd <= a_dat; rsp_err <= bad;
          acc <= '0; newd <= req_data; cnt <= '0; wait_r <= 1'b0;
          fdeg <= failed && cfg_degraded;
          if (bad) st <= S_DONE;
          else if (req_op == 2'd0) begin
            rmask <= d_hit ? (ALL & ~dbit) : dbit;
            wdat <= 1'b0; wpar <= 1'b0; st <= S_RD;
          end else if (req_op == 2'd1) begin
            acc <= req_data; st <= S_RD;
            if (p_hit)      begin rmask <= '0;                  wdat <= 1'b1; wpar <= 1'b0; end
            else if (d_hit) begin rmask <= ALL & ~dbit & ~pbit; wdat <= 1'b0; wpar <= 1'b1; end
            else            begin rmask <= dbit | pbit;         wdat <= 1'b1; wpar <= 1'b1; end
          end else begin
            rmask <= '0; wdat <= 1'b0; wpar <= !p_hit; st <= S_FULL;
          end
        end
        S_RD: begin
          if (dsk_valid && dsk_ready) begin
            rmask  <= rmask & ~(N'(1) << rd_id);
            wait_r <= 1'b1;
          end
          if (wait_r && dsk_rvalid) begin
            acc <= acc ^ dsk_rdata; wait_r <= 1'b0;
          end
          if (rmask == '0 && !wait_r) st <= S_WR;
        end
        S_FULL: if (dat_valid && dat_ready) begin
          acc <= acc ^ dat_in; cnt <= cnt + IW'(1);
          if (cnt == IW'(N-2)) st <= S_WR;
        end
        S_WR: begin
          if (dsk_valid && dsk_ready) begin
            if (wdat) wdat <= 1'b0;
            else      wpar <= 1'b0;
          end
          if (!wdat && !wpar) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module parity_array_engine_chk #(
  parameter int N = 5,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          dsk_valid,
  input logic [IW-1:0] dsk_id,
  input logic          fail_valid,
  input logic          failed,
  input logic          unrecoverable
);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !dsk_valid && !rsp_valid);
  a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
  a_r9_unrec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unrecoverable |=> unrecoverable);
  a_r9_unrec_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unrecoverable) |-> $past(fail_valid) && $past(failed));
  a_r9_failed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    failed |=> failed);
  a_r1_disk_range: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_valid |-> dsk_id < IW'(N));
endmodule

bind parity_array_engine parity_array_engine_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .dsk_valid(dsk_valid), .dsk_id(dsk_id), .fail_valid(fail_valid),
  .failed(failed), .unrecoverable(unrecoverable));

// File: tb/parity_array_engine_test.sv
module parity_array_engine_test;
  localparam int N = 5;
  localparam int DW = 16;
  localparam int SW = 12;
  localparam int IW = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_rotate = 1, cfg_degraded = 0, fail_valid = 0;
  logic [IW-1:0] fail_disk = '0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = '0;
  logic [SW-1:0] req_strip = '0;
  logic [DW-1:0] req_data = '0;
  logic dat_valid = 0, dat_ready;
  logic [DW-1:0] dat_in = '0;
  logic dsk_valid, dsk_ready = 1, dsk_we, dsk_rvalid = 0;
  logic [IW-1:0] dsk_id;
  logic [SW-1:0] dsk_row;
  logic [DW-1:0] dsk_wdata, dsk_rdata = '0;
  logic rsp_valid, rsp_err, failed, unrecoverable;
  logic [DW-1:0] rsp_data;
  logic [IW-1:0] failed_id;

  parity_array_engine #(.N(N), .DW(DW), .SW(SW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, cmd_cnt = 0;
  bit started = 0;
  bit dead [N];
  logic [DW-1:0] mem [N][64];
  logic [DW-1:0] lg [64];
  bit rowrot [16];
  bit m_failed = 0, m_unrec = 0;
  int m_fid = 0;
  logic e; logic [DW-1:0] d;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pdisk(int r);
    return rowrot[r] ? (N-1) - (r % N) : N-1;
  endfunction
  function automatic int ddisk(int s);
    int r = s / (N-1), i = s % (N-1), p;
    p = pdisk(r);
    return (i < p) ? i : i + 1;
  endfunction
  function automatic logic [DW-1:0] rowx(int r);
    logic [DW-1:0] x = '0;
    for (int i = 0; i < N-1; i++) x ^= lg[r*(N-1)+i];
    return x;
  endfunction

  // disk model
  always @(posedge clk) begin
    cyc++;
    dsk_rvalid <= 1'b0;
    if (started) dsk_ready <= ($urandom_range(0, 3) != 0);
    if (rst_n && dsk_valid && dsk_ready) begin
      cmd_cnt++;
      if (dead[dsk_id]) begin
        tests++; fails++;
        $display("FAIL R7 command to failed disk actual=%0d expected=none", dsk_id);
      end
      if (dsk_we) mem[dsk_id][dsk_row[5:0]] <= dsk_wdata;
      else begin
        dsk_rvalid <= 1'b1;
        dsk_rdata  <= dead[dsk_id] ? 16'hBAD0 : mem[dsk_id][dsk_row[5:0]];
      end
    end
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // per-clock comparison of status against model
  always @(negedge clk) if (started) begin
    chk("R9 failed status", failed, m_failed);
    if (m_failed) chk("R9 failed id", failed_id, m_fid);
    chk("R9 unrecoverable status", unrecoverable, m_unrec);
  end

  task automatic issue(input logic [1:0] op, input int strip, input logic [DW-1:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_strip = SW'(strip); req_data = v; cmd_cnt = 0;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_rsp(output logic err, output logic [DW-1:0] v);
    while (!rsp_valid) @(negedge clk);
    err = rsp_err; v = rsp_data;
  endtask

  task automatic rd_chk(input int s, input string tag);
    logic er; logic [DW-1:0] v;
    issue(2'd0, s, '0);
    wait_rsp(er, v);
    chk({tag, " read err"}, er, 0);
    chk({tag, " read data"}, v, lg[s]);
  endtask

  task automatic wr_one(input int s, input logic [DW-1:0] v, output logic er);
    logic [DW-1:0] x;
    issue(2'd1, s, v);
    wait_rsp(er, x);
    if (!er) lg[s] = v;
  endtask

  task automatic full(input int r, input logic [DW-1:0] base, output logic er);
    logic [DW-1:0] x;
    rowrot[r] = cfg_rotate;
    issue(2'd2, r, '0);
    for (int i = 0; i < N-1; i++) begin
      dat_valid = 1; dat_in = base + DW'(i * 16'h0101);
      while (!dat_ready) @(negedge clk);
      lg[r*(N-1)+i] = dat_in;
      @(negedge clk);
    end
    dat_valid = 0;
    wait_rsp(er, x);
  endtask

  task automatic report(input int dk);
    @(negedge clk);
    fail_valid = 1; fail_disk = IW'(dk);
    @(posedge clk);
    if (!m_failed) begin m_failed = 1; m_fid = dk; end
    else if (dk != m_fid) m_unrec = 1;
    @(negedge clk);
    fail_valid = 0;
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      dead[k] = 0;
      for (int j = 0; j < 64; j++) mem[k][j] = '0;
    end
    for (int j = 0; j < 64; j++) lg[j] = '0;
    for (int j = 0; j < 16; j++) rowrot[j] = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset req_ready", req_ready, 1);
    chk("R12 reset rsp_valid", rsp_valid, 0);
    chk("R12 reset dsk_valid", dsk_valid, 0);
    chk("R12 reset failed", failed, 0);
    chk("R12 reset unrecoverable", unrecoverable, 0);
    started = 1;

    // rotating parity, full-stripe writes
    for (int r = 0; r < 6; r++) begin
      full(r, DW'(16'h1000 + r * 16'h0111), e);
      chk("R2 full write err", e, 0);
      chk("R2 full write cmd count", cmd_cnt, N);
      for (int i = 0; i < N-1; i++)
        chk("R1 data placement", mem[ddisk(r*(N-1)+i)][r], lg[r*(N-1)+i]);
      chk("R2 parity value", mem[pdisk(r)][r], rowx(r));
    end
    chk("R1 rotating parity stripe 1 on disk 3", mem[3][1], rowx(1));
    for (int s = 0; s < 24; s++) rd_chk(s, "R4");

    // read-modify-write
    wr_one(1, 16'hA001, e); chk("R3 rmw err", e, 0); chk("R3 rmw cmd count", cmd_cnt, 4);
    chk("R3 rmw parity", mem[pdisk(0)][0], rowx(0));
    chk("R3 rmw data", mem[ddisk(1)][0], 16'hA001);
    wr_one(6, 16'h5A5A, e); chk("R3 rmw err", e, 0);
    chk("R3 rmw parity", mem[pdisk(1)][1], rowx(1));
    wr_one(13, 16'hFFFF, e); chk("R3 rmw parity", mem[pdisk(3)][3], rowx(3));
    wr_one(23, 16'h0000, e); chk("R3 rmw parity", mem[pdisk(5)][5], rowx(5));
    rd_chk(1, "R3"); rd_chk(6, "R3"); rd_chk(13, "R3"); rd_chk(23, "R3");

    // fixed parity disk
    cfg_rotate = 0;
    full(10, 16'h7000, e); chk("R2 fixed full err", e, 0);
    full(11, 16'h7800, e);
    chk("R1 fixed parity on disk N-1", mem[N-1][10], rowx(10));
    chk("R1 fixed parity on disk N-1", mem[N-1][11], rowx(11));
    chk("R1 fixed data position", mem[2][11], lg[11*(N-1)+2]);
    wr_one(41, 16'h1234, e); chk("R3 fixed rmw parity", mem[N-1][10], rowx(10));
    for (int s = 40; s < 48; s++) rd_chk(s, "R1");
    cfg_rotate = 1;

    // reserved op
    issue(2'd3, 0, '0); wait_rsp(e, d);
    chk("R10 reserved op err", e, 1); chk("R10 reserved op no cmd", cmd_cnt, 0);

    // failure report in the acceptance cycle of a read on that disk
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = 2'd0; req_strip = SW'(2); cmd_cnt = 0;
    fail_valid = 1; fail_disk = IW'(2);
    @(posedge clk);
    m_failed = 1; m_fid = 2;
    @(negedge clk);
    req_valid = 0; fail_valid = 0;
    wait_rsp(e, d);
    chk("R11 same-cycle read err", e, 0);
    chk("R11 same-cycle read data", d, lg[2]);
    chk("R11 same-cycle read cmd count", cmd_cnt, 1);
    dead[2] = 1;

    // not degraded
    issue(2'd0, 2, '0); wait_rsp(e, d);
    chk("R8 read failed disk err", e, 1); chk("R8 read failed disk no cmd", cmd_cnt, 0);
    rd_chk(0, "R8 unaffected");
    issue(2'd1, 8, 16'h4444); wait_rsp(e, d);
    chk("R8 write with failed parity err", e, 1); chk("R8 no cmd", cmd_cnt, 0);
    issue(2'd2, 4, '0); wait_rsp(e, d);
    chk("R8 full write err", e, 1); chk("R8 full write no cmd", cmd_cnt, 0);

    // degraded operation
    cfg_degraded = 1;
    rd_chk(2, "R5"); chk("R5 reconstruct cmd count", cmd_cnt, N-1);
    for (int s = 0; s < 24; s++) rd_chk(s, "R5");
    wr_one(2, 16'hC0DE, e);
    chk("R6 data-failed write err", e, 0); chk("R6 data-failed cmd count", cmd_cnt, N-1);
    chk("R6 data-failed parity", mem[pdisk(0)][0], rowx(0));
    rd_chk(2, "R6");
    wr_one(8, 16'hBEEF, e);
    chk("R6 parity-failed write err", e, 0); chk("R6 parity-failed cmd count", cmd_cnt, 1);
    chk("R6 parity-failed data", mem[ddisk(8)][2], 16'hBEEF);
    full(3, 16'h3300, e);
    chk("R7 degraded full err", e, 0); chk("R7 degraded full cmd count", cmd_cnt, N-1);
    chk("R7 degraded full parity", mem[pdisk(3)][3], rowx(3));
    for (int s = 12; s < 16; s++) rd_chk(s, "R7");

    // second failure
    report(2);
    chk("R9 repeat report no unrec", unrecoverable, 0);
    report(4);
    chk("R9 second failure unrec", unrecoverable, 1);
    issue(2'd0, 0, '0); wait_rsp(e, d);
    chk("R9 request after unrec err", e, 1); chk("R9 no cmd", cmd_cnt, 0);
    repeat (3) @(negedge clk);
    chk("R9 unrec sticky", unrecoverable, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule